// File: doc/BRIEF.md
# Five-stage pipelined integer datapath

This block is an in-order integer pipeline for a small load/store instruction set. It covers register-register arithmetic, arithmetic and logic with an immediate, load word and store word. Execution is split into five stages: fetch, decode with register read, execute, memory access and write-back. Pipeline registers separate the stages. Each stage keeps its own copy of the instruction word, and that stage's controls are decoded from that copy. The controls are operand extension and immediate select at decode, the ALU function at execute, the store enable at memory, and the destination and result source at write-back.

The instruction and data memories are separate arrays inside the block, so a fetch and a data access never compete for a port. The program is written through a load port while reset is held. Data memory contents can be read back through a combinational observe port. Every instruction that leaves write-back shows up on the retire outputs.

There is no forwarding. When the instruction in decode reads a register that an older instruction in execute or memory will write, decode holds the program counter and its own instruction register, and a bubble enters execute. The register file passes a same-cycle write through to its read ports, so a producer that has reached write-back needs no stall. Branches, jumps and exceptions are not handled.

Top module: `pl5_core`

## Requirements
- R1: Stage order is fetch, decode, execute, memory, write-back. With no hazards, consecutive instructions retire on consecutive cycles. An instruction whose decode cycle is d retires (ret_valid high) in cycle d+3.
- R2: Instruction fields are op [31:26], rs [25:21], rt [20:16], rd [15:11] and fn [2:0]. Op 1 is a register operation rd <- rs fn rt, where fn 0 is add, 1 subtract, 2 AND, 3 OR, 4 XOR and 5 signed set-less-than (result 1 or 0).
- R3: Op 2 writes rt <- rs + sign-extended imm[15:0]. Op 3 writes rt <- rs OR zero-extended imm[15:0].
- R4: The data memory is word-addressed by (rs + sign-extended imm) modulo DMEM_DEPTH. Op 4 loads that word into rt. Op 5 stores rt to that word and retires with ret_we low.
- R5: Op 0 and every op above 5 are no-ops. They retire valid with ret_we low and read no registers.
- R6: Register 0 always reads as zero. A result aimed at register 0 is dropped and retires with ret_we low.
- R7: While an older instruction in execute or memory will write a nonzero register that the decode instruction reads as rs or rt, decode holds its instruction and a bubble enters execute. The consumer's decode cycle therefore comes at least 3 cycles after the producer's.
- R8: A producer in write-back does not stall decode. The register file returns the value being written in the same cycle, so a consumer 3 instructions behind runs without a gap.
- R9: A bubble retires with ret_valid low and ret_we low, and it writes neither memory nor registers.
- R10: While rst_n is low, all stage valid bits are clear and the program counter is 0. The first fetch after release reads instruction address 0.
- R11: While ld_we is high, ld_data is written to instruction word ld_addr. obs_data shows data word obs_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| ld_we | input | 1 | Instruction memory write enable |
| ld_addr | input | $clog2(IMEM_DEPTH) | Instruction memory write address (words) |
| ld_data | input | 32 | Instruction word to write |
| obs_addr | input | $clog2(DMEM_DEPTH) | Data memory observe address (words) |
| obs_data | output | XLEN | Data word at obs_addr |
| ret_valid | output | 1 | A real instruction is in write-back |
| ret_we | output | 1 | The write-back instruction writes a register |
| ret_reg | output | 5 | Destination register of the write-back instruction |
| ret_data | output | XLEN | Result being written back |

## Verification
The assertions check the stall mechanics on every cycle. A stall must hold the decode instruction and its valid bit and send a bubble into execute. An unstalled valid decode instruction must move into execute. No stall may occur while execute and memory are empty, stores may happen only from a valid memory stage, and reset must clear every valid bit. The scenarios are the only way to show the results. They check every ALU function over signed and unsigned corner operands, immediate extension, address wrap, load-use ordering, and the exact retire cycle of every instruction at dependency distances of one, two and three. That retire cycle is where the number of stall cycles shows, and also the write-back pass-through.

// File: rtl/pl5_pkg.sv
package pl5_pkg;
  localparam int ILEN = 32;
  localparam int RW   = 5;

  localparam logic [5:0] OP_RALU = 6'd1;
  localparam logic [5:0] OP_ADDI = 6'd2;
  localparam logic [5:0] OP_ORI  = 6'd3;
  localparam logic [5:0] OP_LDW  = 6'd4;
  localparam logic [5:0] OP_STW  = 6'd5;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_AND = 3'd2,
    FN_OR  = 3'd3, FN_XOR = 3'd4, FN_SLT = 3'd5
  } fn_e;

  // Source usage seen by the hazard unit.
  function automatic logic uses_rs(input logic [ILEN-1:0] ir);
    return ir[31:26] inside {OP_RALU, OP_ADDI, OP_ORI, OP_LDW, OP_STW};
  endfunction

  function automatic logic uses_rt(input logic [ILEN-1:0] ir);
    return ir[31:26] inside {OP_RALU, OP_STW};
  endfunction

  // Destination register; zero means the instruction writes nothing.
  function automatic logic [RW-1:0] dest_of(input logic [ILEN-1:0] ir);
    case (ir[31:26])
      OP_RALU:                return ir[15:11];
      OP_ADDI, OP_ORI, OP_LDW: return ir[20:16];
      default:                return '0;
    endcase
  endfunction

  // Decode-stage controls: immediate extension and operand-B source.
  function automatic logic sign_ext(input logic [ILEN-1:0] ir);
    return ir[31:26] != OP_ORI;
  endfunction

  function automatic logic takes_imm(input logic [ILEN-1:0] ir);
    return ir[31:26] inside {OP_ADDI, OP_ORI, OP_LDW, OP_STW};
  endfunction

  // Execute-stage control.
  function automatic fn_e alu_fn(input logic [ILEN-1:0] ir);
    case (ir[31:26])
      OP_RALU: return fn_e'(ir[2:0]);
      OP_ORI:  return FN_OR;
      default: return FN_ADD;
    endcase
  endfunction

  // Memory- and write-back-stage controls.
  function automatic logic is_store(input logic [ILEN-1:0] ir);
    return ir[31:26] == OP_STW;
  endfunction

  function automatic logic is_load(input logic [ILEN-1:0] ir);
    return ir[31:26] == OP_LDW;
  endfunction
endpackage

// File: rtl/pl5_regfile.sv
module pl5_regfile #(
  parameter int XLEN = 32,
  parameter int RW   = 5,
  localparam int NREG = 1 << RW
) (
  input  logic            clk,
  input  logic [RW-1:0]   ra,
  input  logic [RW-1:0]   rb,
  input  logic            we,
  input  logic [RW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  output logic [XLEN-1:0] qa,
  output logic [XLEN-1:0] qb
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  // Same-cycle write is passed through to the readers.
  always_comb begin
    if (ra == '0)                qa = '0;
    else if (we && wa == ra)     qa = wd;
    else                         qa = mem[ra];
    if (rb == '0)                qb = '0;
    else if (we && wa == rb)     qb = wd;
    else                         qb = mem[rb];
  end
endmodule

// File: rtl/pl5_alu.sv
module pl5_alu import pl5_pkg::*; #(
  parameter int XLEN = 32
) (
  input  fn_e             fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pl5_hazard.sv
module pl5_hazard import pl5_pkg::*; #(
  parameter int NPROD = 2
) (
  input  logic                       id_v,
  input  logic [ILEN-1:0]            id_ir,
  input  logic [NPROD-1:0]           prod_v,
  input  logic [NPROD-1:0][ILEN-1:0] prod_ir,
  output logic                       stall
);
  logic [NPROD-1:0] hit;
  logic [RW-1:0]    rs, rt;
  logic             need_rs, need_rt;

  assign rs      = id_ir[25:21];
  assign rt      = id_ir[20:16];
  assign need_rs = uses_rs(id_ir);
  assign need_rt = uses_rt(id_ir);

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    logic [RW-1:0] dst;
    assign dst    = dest_of(prod_ir[g]);
    assign hit[g] = prod_v[g] && dst != '0 &&
                    ((need_rs && dst == rs) || (need_rt && dst == rt));
  end

  assign stall = id_v && (|hit);
endmodule

// File: rtl/pl5_core.sv
module pl5_core import pl5_pkg::*; #(
  parameter int XLEN       = 32,
  parameter int IMEM_DEPTH = 128,
  parameter int DMEM_DEPTH = 64,
  localparam int IA_W      = $clog2(IMEM_DEPTH),
  localparam int DA_W      = $clog2(DMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [IA_W-1:0] ld_addr,
  input  logic [31:0]     ld_data,
  input  logic [DA_W-1:0] obs_addr,
  output logic [XLEN-1:0] obs_data,
  output logic            ret_valid,
  output logic            ret_we,
  output logic [4:0]      ret_reg,
  output logic [XLEN-1:0] ret_data
);
  logic [ILEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];

  // Stage state: program counter, valid bits, per-stage instruction copies.
  logic [IA_W-1:0] pc_q, pc_n;
  logic            v_id_q, v_ex_q, v_ma_q, v_wb_q, v_ex_n;
  logic [ILEN-1:0] ir_id_q, ir_id_n, ir_ex_q, ir_ex_n, ir_ma_q, ir_wb_q;
  logic [XLEN-1:0] a_ex_q, a_ex_n, b_ex_q, b_ex_n, sd_ex_q, sd_ex_n;
  logic [XLEN-1:0] alu_ma_q, alu_ma_n, sd_ma_q;
  logic [XLEN-1:0] alu_wb_q, ld_wb_q, ld_wb_n;

  logic            stall, dm_we, wb_we;
  logic [RW-1:0]   wb_dst;
  logic [XLEN-1:0] rf_a, rf_b, wb_val, imm_ext;
  fn_e             ex_fn;

  pl5_hazard #(.NPROD(2)) u_hz (
    .id_v    (v_id_q),
    .id_ir   (ir_id_q),
    .prod_v  ({v_ex_q, v_ma_q}),
    .prod_ir ({ir_ex_q, ir_ma_q}),
    .stall   (stall)
  );

  pl5_regfile #(.XLEN(XLEN), .RW(RW)) u_rf (
    .clk (clk),
    .ra  (ir_id_q[25:21]),
    .rb  (ir_id_q[20:16]),
    .we  (wb_we),
    .wa  (wb_dst),
    .wd  (wb_val),
    .qa  (rf_a),
    .qb  (rf_b)
  );

  assign ex_fn = alu_fn(ir_ex_q);

  pl5_alu #(.XLEN(XLEN)) u_alu (
    .fn (ex_fn),
    .a  (a_ex_q),
    .b  (b_ex_q),
    .y  (alu_ma_n)
  );

  // Next-state logic; each stage decodes only its own instruction copy.
  always_comb begin
    pc_n    = pc_q + IA_W'(1);
    ir_id_n = imem[pc_q];
    // decode stage: extension and operand select
    imm_ext = sign_ext(ir_id_q) ? {{(XLEN-16){ir_id_q[15]}}, ir_id_q[15:0]}
                                : {{(XLEN-16){1'b0}},        ir_id_q[15:0]};
    v_ex_n  = v_id_q && !stall;
    ir_ex_n = v_ex_n ? ir_id_q : '0;          // bubble carries a no-op
    a_ex_n  = rf_a;
    b_ex_n  = takes_imm(ir_id_q) ? imm_ext : rf_b;
    sd_ex_n = rf_b;
    // memory stage
    dm_we   = v_ma_q && is_store(ir_ma_q);
    ld_wb_n = dmem[alu_ma_q[DA_W-1:0]];
    // write-back stage
    wb_dst  = dest_of(ir_wb_q);
    wb_we   = v_wb_q && wb_dst != '0;
    wb_val  = is_load(ir_wb_q) ? ld_wb_q : alu_wb_q;
  end

  // Control registers with asynchronous reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      v_id_q <= 1'b0;
      v_ex_q <= 1'b0;
      v_ma_q <= 1'b0;
      v_wb_q <= 1'b0;
    end else begin
      if (!stall) begin
        pc_q   <= pc_n;
        v_id_q <= 1'b1;
      end
      v_ex_q <= v_ex_n;
      v_ma_q <= v_ex_q;
      v_wb_q <= v_ma_q;
    end
  end

  // Datapath registers: no reset, qualified by the valid bits.
  always_ff @(posedge clk) begin
    if (!stall) ir_id_q <= ir_id_n;
    ir_ex_q  <= ir_ex_n;
    a_ex_q   <= a_ex_n;
    b_ex_q   <= b_ex_n;
    sd_ex_q  <= sd_ex_n;
    ir_ma_q  <= ir_ex_q;
    alu_ma_q <= alu_ma_n;
    sd_ma_q  <= sd_ex_q;
    ir_wb_q  <= ir_ma_q;
    alu_wb_q <= alu_ma_q;
    ld_wb_q  <= ld_wb_n;
  end

  always_ff @(posedge clk) begin
    if (ld_we) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_ma_q[DA_W-1:0]] <= sd_ma_q;
  end

  assign obs_data  = dmem[obs_addr];
  assign ret_valid = v_wb_q;
  assign ret_we    = wb_we;
  assign ret_reg   = wb_dst;
  assign ret_data  = wb_val;
endmodule

// File: rtl/pl5_core_chk.sv
module pl5_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic [31:0] ir_id,
  input logic        v_id,
  input logic        v_ex,
  input logic        v_ma,
  input logic        v_wb,
  input logic        dm_we
);
  // R7: a stalled decode keeps its instruction and valid bit
  a_r7_hold_id: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(ir_id) && v_id));

  // R7: a stall puts a bubble into execute
  a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !v_ex);

  // R1: an unstalled valid decode instruction moves into execute
  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (v_id && !stall) |=> v_ex);

  // R7: with no producers in flight there is nothing to wait for
  a_r7_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_ex && !v_ma) |-> !stall);

  // R9: memory is written only by a real instruction
  a_r9_store_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> v_ma);

  // R10: reset keeps every stage empty
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_clear: assert (!v_id && !v_ex && !v_ma && !v_wb);
    end
  end
endmodule

bind pl5_core pl5_core_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .stall (stall),
  .ir_id (ir_id_q),
  .v_id  (v_id_q),
  .v_ex  (v_ex_q),
  .v_ma  (v_ma_q),
  .v_wb  (v_wb_q),
  .dm_we (dm_we)
);

// File: tb/sim_pl5_core.sv
module sim_pl5_core;
  localparam int XLEN = 32, IMEM_DEPTH = 128, DMEM_DEPTH = 64;
  localparam int IA_W = $clog2(IMEM_DEPTH), DA_W = $clog2(DMEM_DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic            rst_n, ld_we;
  logic [IA_W-1:0] ld_addr;
  logic [31:0]     ld_data;
  logic [DA_W-1:0] obs_addr;
  logic [XLEN-1:0] obs_data;
  logic            ret_valid, ret_we;
  logic [4:0]      ret_reg;
  logic [XLEN-1:0] ret_data;

  pl5_core #(.XLEN(XLEN), .IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .obs_addr(obs_addr), .obs_data(obs_data), .ret_valid(ret_valid),
    .ret_we(ret_we), .ret_reg(ret_reg), .ret_data(ret_data));

  int checks = 0, fails = 0, cyc = 0, ridx = 0, plen = 0;
  int bub_cycles = 0, bub_writes = 0;
  bit running = 1'b0;

  logic [31:0] prog  [IMEM_DEPTH];
  logic [4:0]  e_reg [IMEM_DEPTH];
  bit          e_we  [IMEM_DEPTH];
  logic [31:0] e_val [IMEM_DEPTH];
  int          e_cyc [IMEM_DEPTH];
  string       e_tag [IMEM_DEPTH];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DMEM_DEPTH];
  bit          m_wr  [DMEM_DEPTH];

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int fn, input int rd, input int rs, input int rt);
    return {6'd1, 5'(rs), 5'(rt), 5'(rd), 8'd0, 3'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rt, input int rs, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  function automatic logic [31:0] m_alu(input int fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // Instruction-level model with the stall timing rules of R1, R7, R8.
  task automatic model();
    int last [32];
    int id_prev;
    id_prev = 0;
    for (int r = 0; r < 32; r++) begin last[r] = -100; m_reg[r] = '0; end
    for (int a = 0; a < DMEM_DEPTH; a++) m_wr[a] = 1'b0;
    for (int n = 0; n < plen; n++) begin
      logic [31:0] w, a, b, se, ze, v, ad;
      int op, rs, rt, rd, fn, dst, id;
      bit ua, ub, wr;
      string tag;
      w = prog[n]; op = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]);
      rd = int'(w[15:11]); fn = int'(w[2:0]);
      a = m_reg[rs]; b = m_reg[rt];
      se = {{16{w[15]}}, w[15:0]}; ze = {16'd0, w[15:0]};
      v = '0; dst = 0; ua = 0; ub = 0; wr = 0; tag = "R5";
      ad = a + se;
      case (op)
        1: begin ua = 1; ub = 1; wr = 1; dst = rd; v = m_alu(fn, a, b); tag = "R2"; end
        2: begin ua = 1; wr = 1; dst = rt; v = a + se; tag = "R3"; end
        3: begin ua = 1; wr = 1; dst = rt; v = a | ze; tag = "R3"; end
        4: begin ua = 1; wr = 1; dst = rt; v = m_mem[ad[DA_W-1:0]]; tag = "R4"; end
        5: begin ua = 1; ub = 1; m_mem[ad[DA_W-1:0]] = b; m_wr[ad[DA_W-1:0]] = 1'b1; tag = "R4"; end
        default: ;
      endcase
      id = id_prev + 1;
      if (ua && rs != 0 && last[rs] + 3 > id) id = last[rs] + 3;
      if (ub && rt != 0 && last[rt] + 3 > id) id = last[rt] + 3;
      if (wr && dst == 0) tag = "R6";
      e_we[n]  = wr && dst != 0;
      e_reg[n] = 5'(dst);
      e_val[n] = v;
      e_tag[n] = tag;
      if (e_we[n]) begin m_reg[dst] = v; last[dst] = id; end
      e_cyc[n] = id + 3;
      id_prev = id;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Retire monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      if (!ret_valid) begin
        bub_cycles++;
        if (ret_we) bub_writes++;
      end else if (ridx < plen) begin
        chk(cyc == e_cyc[ridx], $sformatf("%s R1 R7 R8 retire cycle of instr %0d", e_tag[ridx], ridx),
            32'(cyc), 32'(e_cyc[ridx]));
        chk(ret_we == e_we[ridx], $sformatf("%s R6 write enable of instr %0d", e_tag[ridx], ridx),
            32'(ret_we), 32'(e_we[ridx]));
        if (e_we[ridx]) begin
          chk(ret_reg == e_reg[ridx], $sformatf("%s destination of instr %0d", e_tag[ridx], ridx),
              32'(ret_reg), 32'(e_reg[ridx]));
          chk(ret_data == e_val[ridx], $sformatf("%s result of instr %0d", e_tag[ridx], ridx),
              ret_data, e_val[ridx]);
        end
        ridx++;
      end
    end
  end

  initial begin
    int k, wd;
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0; obs_addr = '0;

    // Operand set: -1, 0x8001, 5, 0xFFFF8000
    emit(enc_i(2, 1, 0, 16'hFFFF));
    emit(enc_i(3, 2, 0, 16'h8001));
    emit(enc_i(2, 3, 0, 5));
    emit(enc_i(2, 4, 0, 16'h8000));
    // R2 sweep: every function over every operand pair
    k = 0;
    for (int fn = 0; fn < 6; fn++)
      for (int i = 1; i <= 4; i++)
        for (int j = 1; j <= 4; j++) begin
          emit(enc_r(fn, 5 + (k % 15), i, j));
          k++;
        end
    // Memory and hazard section
    emit(enc_i(3, 20, 0, 7));            // r20 = 7
    emit(enc_i(5, 1, 20, 2));            // store r1 -> 9, distance-1 dependency
    emit(enc_i(5, 2, 20, 16'hFFFD));     // store r2 -> 4, negative offset
    emit(enc_i(5, 3, 1, 16'h0041));      // store r3 -> 64 wraps to 0
    emit(enc_i(4, 21, 20, 2));           // load r21 <- 9
    emit(enc_r(0, 22, 21, 3));           // load-use
    emit(enc_r(0, 0, 1, 1));             // write to r0 dropped
    emit(enc_r(0, 23, 0, 3));            // reads r0
    emit(enc_i(2, 24, 23, 1));           // distance 1
    emit(32'd0);
    emit(enc_i(2, 25, 24, 1));           // distance 2
    emit(32'd0);
    emit(32'd0);
    emit(enc_i(2, 26, 25, 1));           // distance 3: write-back pass-through
    emit(enc_i(5, 26, 0, 12));           // store r26 -> 12
    emit(enc_i(4, 27, 0, 12));           // load it back
    emit(enc_r(5, 28, 27, 1));           // signed compare on loaded value
    emit(enc_i(4, 29, 20, 16'hFFFD));    // load from 4
    emit(enc_i(5, 29, 0, 63));           // store to the top word
    emit(enc_i(4, 30, 1, 1));            // load from 0 (wrapped store)
    emit(32'hFC00_0000);                 // unknown opcode: no-op
    model();

    repeat (2) @(negedge clk);
    chk(ret_valid == 1'b0, "R10 retire valid during reset", 32'(ret_valid), 32'd0);
    for (int i = 0; i < IMEM_DEPTH; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = IA_W'(i); ld_data = (i < plen) ? prog[i] : 32'd0;
    end
    @(negedge clk);
    ld_we = 1'b0;
    chk(ret_valid == 1'b0 && ret_we == 1'b0, "R10 R11 pipeline empty after program load",
        32'({ret_valid, ret_we}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1; running = 1'b1;

    wd = 0;
    while (ridx < plen && wd < 4000) begin
      @(negedge clk);
      wd++;
    end
    running = 1'b0;
    if (ridx < plen) chk(1'b0, "R1 watchdog expired before all retires", 32'(ridx), 32'(plen));
    chk(bub_writes == 0 && bub_cycles > 0, "R9 bubbles retire without writes", 32'(bub_writes), 32'd0);

    for (int a = 0; a < DMEM_DEPTH; a++) begin
      if (m_wr[a]) begin
        @(negedge clk);
        obs_addr = DA_W'(a);
        #1;
        chk(obs_data == m_mem[a], $sformatf("R4 R11 data word %0d", a), obs_data, m_mem[a]);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule